// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block sets the timing of one conversion of a successive-approximation converter that is clocked from an external master clock. A conversion is started in one of two ways. The first is a rising edge on a hardware start pin. The second is a one-cycle pulse that marks the end of a control write that sets the software start bit. When a conversion starts, the block raises a hold signal to the track-and-hold and raises busy in the same cycle. It then waits for the next falling edge of the master clock and counts a fixed number of master-clock half-periods. At the end of that count, hold and busy drop together and tracking resumes.

The block runs on a clock at twice the master rate, so one cycle of `clk_i` is one master half-period. It produces the master clock phase itself on `mclk_o`. An external setup comparison is supplied as `setup_met_i` and passes through a synchronizer. If setup was met, the conversion lasts 16.5 master periods (33 half-periods). If it was missed, the conversion lasts 17.5 master periods (35 half-periods). The software start bit clears itself when busy falls, so it can be written again. The first start after reset runs a calibration pass instead of a plain conversion, and that pass has a length of its own.

Top module: `conv_start_seq`

## Requirements
- R1: While `rst_ni` is low and directly after reset, `busy_o`, `hold_o`, `sw_start_o`, `cal_o` and `mclk_o` are all 0.
- R2: A 0-to-1 change on `start_pin_i` that is sampled at a `clk_i` edge while `busy_o` is 0 sets both `busy_o` and `hold_o` to 1 after that edge.
- R3: A pulse on `sw_set_i` that is sampled while `busy_o` is 0 starts a conversion in the same way as R2. It also sets `sw_start_o` to 1 on the same edge.
- R4: Counting starts at the first falling master edge strictly after the start edge. This is an edge at which `mclk_o` goes from 1 to 0. If the synchronized setup flag was 1 at the start edge, `busy_o` falls 33 `clk_i` edges after that falling edge.
- R5: If the synchronized setup flag was 0 at the start edge, `busy_o` falls 35 `clk_i` edges after that falling master edge.
- R6: `setup_met_i` passes through a synchronizer of `SYNC_STAGES` flops, which is 2 by default. A change that is driven in the same cycle as the start edge does not affect that conversion.
- R7: `hold_o` is 1 for exactly as long as `busy_o` is 1, and the two fall on the same edge.
- R8: `sw_start_o` returns to 0 on the edge where `busy_o` falls.
- R9: The first start after reset is a calibration pass. During that pass `cal_o` is 1 for the whole time `busy_o` is high, and `busy_o` falls `CAL_HALVES` edges after the aligning falling edge. Later starts have `cal_o` at 0.
- R10: A pin edge or a `sw_set_i` pulse that arrives while `busy_o` is 1 is ignored. The conversion length does not change, `sw_start_o` keeps its value, and no new conversion follows.
- R11: Only a rising edge of `start_pin_i` starts a conversion. If the pin is held high after a conversion ends, no new conversion starts.
- R12: `mclk_o` toggles on every `clk_i` edge and is 0 right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the master clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_pin_i | input | 1 | Hardware start pin, acts on its rising edge |
| sw_set_i | input | 1 | Pulse at the end of a control write that sets the software start bit |
| setup_met_i | input | 1 | Start edge met the setup window before the next falling master edge |
| mclk_o | output | 1 | Master clock phase, 1 means high |
| hold_o | output | 1 | Track-and-hold in hold mode |
| busy_o | output | 1 | Conversion or calibration in progress |
| sw_start_o | output | 1 | Software start bit |
| cal_o | output | 1 | Current busy period is the power-up calibration pass |

## Verification
The assertions check a set of rules on every cycle. `mclk_o` alternates. An idle pin edge starts busy. `hold_o` and `sw_start_o` fall with busy. The software bit never changes while busy is high. `cal_o` is only seen inside a busy period, and no busy period runs past the longest allowed length. The bench covers the exact busy length, which depends on the master phase at the start, on the synchronized setup flag and on whether this is the first start after reset. It sweeps both start sources, both phases and both setup values. It also drives starts during busy, a setup change in the same cycle as the start, and a pin held high, none of which the per-cycle rules can pin down.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_COUNT = 2'd2
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/conv_seq_sync.sv
module conv_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/conv_seq_start.sv
module conv_seq_start (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pin_i,
  input  logic sw_set_i,
  input  logic idle_i,
  input  logic done_i,
  output logic start_evt_o,
  output logic sw_bit_o
);
  logic pin_q;
  logic sw_q;
  logic pin_rise;

  assign pin_rise    = start_pin_i & ~pin_q;
  assign start_evt_o = idle_i & (pin_rise | sw_set_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      pin_q <= start_pin_i;
      if (done_i)                 sw_q <= 1'b0;
      else if (idle_i && sw_set_i) sw_q <= 1'b1;
    end
  end

  assign sw_bit_o = sw_q;
endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer
  import conv_seq_pkg::*;
#(
  parameter int FAST_HALVES = 33,
  parameter int CAL_HALVES  = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_evt_i,
  input  logic setup_i,
  output logic mclk_o,
  output logic busy_o,
  output logic hold_o,
  output logic cal_o,
  output logic done_o
);
  localparam int SLOW_HALVES = FAST_HALVES + 2;
  localparam int MAX_HALVES  = max_int(SLOW_HALVES, CAL_HALVES);
  localparam int CNT_W       = $clog2(MAX_HALVES + 1);

  seq_state_e       state_q;
  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             busy_q, hold_q, cal_q, cal_pend_q;
  logic             last_half;

  assign last_half = (state_q == ST_COUNT) && (cnt_q == len_q - CNT_W'(1));
  assign done_o    = last_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= 1'b0;
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      len_q      <= '0;
      busy_q     <= 1'b0;
      hold_q     <= 1'b0;
      cal_q      <= 1'b0;
      cal_pend_q <= 1'b1;
    end else begin
      ph_q <= ~ph_q;
      unique case (state_q)
        ST_IDLE: begin
          if (start_evt_i) begin
            state_q    <= ST_ALIGN;
            busy_q     <= 1'b1;
            hold_q     <= 1'b1;
            cal_q      <= cal_pend_q;
            cal_pend_q <= 1'b0;
            if (cal_pend_q)   len_q <= CNT_W'(CAL_HALVES);
            else if (setup_i) len_q <= CNT_W'(FAST_HALVES);
            else              len_q <= CNT_W'(SLOW_HALVES);
          end
        end
        ST_ALIGN: begin
          // ph_q high now: this edge is the master falling edge
          if (ph_q) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
          end
        end
        ST_COUNT: begin
          if (last_half) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            hold_q  <= 1'b0;
            cal_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mclk_o = ph_q;
  assign busy_o = busy_q;
  assign hold_o = hold_q;
  assign cal_o  = cal_q;
endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq #(
  parameter int FAST_HALVES = 33,
  parameter int CAL_HALVES  = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pin_i,
  input  logic sw_set_i,
  input  logic setup_met_i,
  output logic mclk_o,
  output logic hold_o,
  output logic busy_o,
  output logic sw_start_o,
  output logic cal_o
);
  logic setup_sync;
  logic start_evt;
  logic done;
  logic busy;

  conv_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (setup_met_i),
    .q_o    (setup_sync)
  );

  conv_seq_start u_start (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_pin_i (start_pin_i),
    .sw_set_i    (sw_set_i),
    .idle_i      (~busy),
    .done_i      (done),
    .start_evt_o (start_evt),
    .sw_bit_o    (sw_start_o)
  );

  conv_seq_timer #(
    .FAST_HALVES (FAST_HALVES),
    .CAL_HALVES  (CAL_HALVES)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_evt_i (start_evt),
    .setup_i     (setup_sync),
    .mclk_o      (mclk_o),
    .busy_o      (busy),
    .hold_o      (hold_o),
    .cal_o       (cal_o),
    .done_o      (done)
  );

  assign busy_o = busy;
endmodule

// File: rtl/conv_start_seq_chk.sv
module conv_start_seq_chk #(
  parameter int FAST_HALVES = 33,
  parameter int CAL_HALVES  = 96
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_pin_i,
  input logic sw_set_i,
  input logic mclk_o,
  input logic hold_o,
  input logic busy_o,
  input logic sw_start_o,
  input logic cal_o
);
  localparam int MAX_BUSY = ((CAL_HALVES > FAST_HALVES + 2) ? CAL_HALVES : FAST_HALVES + 2) + 2;

  logic       seen_q;
  logic       pin_q;
  logic       mclk_q;
  logic       busy_q;
  logic       hold_q;
  logic       sw_q;
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      pin_q  <= 1'b0;
      mclk_q <= 1'b0;
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      sw_q   <= 1'b0;
      run_q  <= 0;
    end else begin
      seen_q <= 1'b1;
      pin_q  <= start_pin_i;
      mclk_q <= mclk_o;
      busy_q <= busy_o;
      hold_q <= hold_o;
      sw_q   <= sw_start_o;
      run_q  <= busy_o ? run_q + 1 : 0;
    end
  end

  // R12
  p_mclk_toggle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (mclk_o != mclk_q));

  // R2
  p_pin_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !busy_o && start_pin_i && !pin_q) |=> (busy_o && hold_o));

  // R7
  p_hold_with_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && busy_q && !busy_o) |-> (hold_q && !hold_o));

  // R8
  p_sw_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && busy_q && !busy_o) |-> !sw_start_o);

  // R10
  p_sw_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && busy_q && busy_o) |-> (sw_start_o == sw_q));

  // R3
  p_sw_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !sw_q && sw_start_o) |-> (!busy_q && busy_o));

  // R9
  p_cal_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> busy_o);

  // R4 / R5 / R9 upper bound
  p_busy_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= MAX_BUSY);

  p_unused_sw_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && sw_set_i && !busy_o) |=> busy_o);
endmodule

bind conv_start_seq conv_start_seq_chk #(
  .FAST_HALVES (FAST_HALVES),
  .CAL_HALVES  (CAL_HALVES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_pin_i (start_pin_i),
  .sw_set_i    (sw_set_i),
  .mclk_o      (mclk_o),
  .hold_o      (hold_o),
  .busy_o      (busy_o),
  .sw_start_o  (sw_start_o),
  .cal_o       (cal_o)
);

// File: tb/tb_conv_start_seq.sv
`timescale 1ns/1ps
module tb_conv_start_seq;
  localparam int FAST = 33;
  localparam int SLOW = 35;
  localparam int CAL  = 96;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_pin_i = 1'b0;
  logic sw_set_i = 1'b0;
  logic setup_met_i = 1'b0;
  logic mclk_o, hold_o, busy_o, sw_start_o, cal_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  conv_start_seq #(.FAST_HALVES(FAST), .CAL_HALVES(CAL), .SYNC_STAGES(2)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_pin_i (start_pin_i),
    .sw_set_i    (sw_set_i),
    .setup_met_i (setup_met_i),
    .mclk_o      (mclk_o),
    .hold_o      (hold_o),
    .busy_o      (busy_o),
    .sw_start_o  (sw_start_o),
    .cal_o       (cal_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; setup_now = synced flag at start, setup_drv = value driven at start cycle
  task automatic run_conv(input bit use_sw, input bit setup_now, input bit setup_drv,
                          input bit exp_cal, input bit poke, input bit keep_pin,
                          input int skew);
    int w, n, exp_len;
    for (int i = 0; i < skew; i++) @(negedge clk_i);
    setup_met_i = setup_drv;
    if (use_sw) sw_set_i = 1'b1; else start_pin_i = 1'b1;
    @(negedge clk_i);
    sw_set_i = 1'b0;
    if (!keep_pin) start_pin_i = 1'b0;
    check(busy_o && hold_o, use_sw ? "R3 busy/hold on sw start" : "R2 busy/hold on pin edge",
          {busy_o, hold_o}, 3);
    check(sw_start_o == use_sw, "R3 sw bit value", sw_start_o, use_sw);
    check(cal_o == exp_cal, "R9 cal flag", cal_o, exp_cal);
    w = mclk_o ? 1 : 2;
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      if (!hold_o) check(1'b0, "R7 hold low during busy", hold_o, 1);
      if (busy_o && cal_o != exp_cal) check(1'b0, "R9 cal held", cal_o, exp_cal);
      if (poke && n == 10) begin
        sw_set_i = 1'b1;
        if (!keep_pin) start_pin_i = 1'b1;
      end
      if (poke && n == 11) begin
        sw_set_i = 1'b0;
        if (!keep_pin) start_pin_i = 1'b0;
        check(sw_start_o == use_sw, "R10 sw bit unchanged by busy write", sw_start_o, use_sw);
      end
      @(negedge clk_i);
    end
    exp_len = w + (exp_cal ? CAL : (setup_now ? FAST : SLOW));
    check(n == exp_len, exp_cal ? "R9 cal length" : (setup_now ? "R4 fast length" : "R5 slow length"),
          n, exp_len);
    check(!hold_o, "R7 hold falls with busy", hold_o, 0);
    check(!sw_start_o, "R8 sw bit cleared", sw_start_o, 0);
    if (poke || keep_pin) begin
      for (int i = 0; i < 6; i++) @(negedge clk_i);
      check(!busy_o, keep_pin ? "R11 level does not retrigger" : "R10 no start after busy poke",
            busy_o, 0);
    end
    start_pin_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({busy_o, hold_o, sw_start_o, cal_o, mclk_o} == 5'b0, "R1 reset state",
          {busy_o, hold_o, sw_start_o, cal_o, mclk_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(mclk_o == 1'b1, "R12 mclk after first edge", mclk_o, 1);
    check(!busy_o && !sw_start_o, "R1 idle after reset", busy_o, 0);
    @(negedge clk_i);
    check(mclk_o == 1'b0, "R12 mclk toggles", mclk_o, 0);

    // R9 first start is calibration
    run_conv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);

    // sweep source x setup x phase
    for (int src = 0; src < 2; src++)
      for (int s = 0; s < 2; s++)
        for (int sk = 0; sk < 2; sk++) begin
          setup_met_i = s[0];
          repeat (4) @(negedge clk_i);
          run_conv(src[0], s[0], s[0], 1'b0, 1'b0, 1'b0, sk);
        end

    // R6 setup change in start cycle ignored: old value 0 applies
    setup_met_i = 1'b0;
    repeat (4) @(negedge clk_i);
    run_conv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    // R6 reverse: old 1 applies
    setup_met_i = 1'b1;
    repeat (4) @(negedge clk_i);
    run_conv(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1);

    // R10 pokes during busy, both sources
    setup_met_i = 1'b1;
    repeat (4) @(negedge clk_i);
    run_conv(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    run_conv(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1);

    // R11 pin held high through and after conversion
    setup_met_i = 1'b0;
    repeat (4) @(negedge clk_i);
    run_conv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule